// File: doc/BRIEF.md
# Shared Tagged Receive Queue

This block collects received characters from a group of serial lines into one first-in, first-out queue that a host drains one word at a time. Each stored word carries the character, the number of the line it arrived on, a valid marker and the framing and parity error flags reported by that line's receiver. When the local loopback control is on, a completed transmission on any line is also written into the queue as if it had been received on that line.

Every line offers two producers: its receiver and its transmit-completion loopback source. Each producer has a valid/ready handshake. A producer raises valid with its payload and must hold both unchanged until it sees ready high at a rising clock edge. Ready high means the word was consumed in that cycle: it was either stored or, if the queue was full, discarded. At most one producer is consumed per clock. A producer that is not selected sees ready low and keeps waiting. The host side is a plain read strobe. Each strobe pops the oldest word, which appears on the read data port one clock later. A strobe on an empty queue returns zero. A status flag reports that received data is waiting.

Top module: `tagged_rx_queue`

## Requirements
- R1: A stored word has this layout: bit 15 valid (always 1), bit 14 overrun (always 0), bit 13 framing error, bit 12 parity error, bits 11:10 zero, bits 9:8 the line number, bits 7:0 the character.
- R2: At most one producer is consumed per clock. The producers are ranked by line number, lowest line first, and within a line the receiver comes before the loopback source. A producer that is passed over sees ready low and is consumed in a later cycle.
- R3: A producer consumed while the queue holds its full depth (64 words) is discarded. Its ready is still high, and the queue contents and order are unchanged.
- R4: Every word that is stored sets the receive-done flag at the clock edge that stores it.
- R5: A read strobe on an empty queue gives zero on the read data port and clears the receive-done flag.
- R6: A read that leaves the queue empty clears the receive-done flag, so the flag is high exactly when the queue holds at least one word.
- R7: While loopback is on, a transmit completion stores the transmitted character with its line number, the valid bit set and no error bits. While loopback is off, transmit completions are consumed at once (ready high) and store nothing.
- R8: A reset or a synchronous clear empties the queue, clears receive-done and zeroes the read data port. Clear takes priority over any push or read in the same cycle.
- R9: A store and a read in the same cycle leave the number of queued words unchanged and keep the receive-done flag high.
- R10: Reads return words in the order they were stored, each on the read data port one clock after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the queue |
| loop_en | input | 1 | Local loopback on |
| rx_valid | input | NUM_LINES | Receiver word offered, one bit per line |
| rx_ready | output | NUM_LINES | Receiver word consumed this cycle |
| rx_byte | input | 8*NUM_LINES | Received character, line n at bits 8n+7:8n |
| rx_ferr | input | NUM_LINES | Framing error with the received character |
| rx_perr | input | NUM_LINES | Parity error with the received character |
| tx_done_valid | input | NUM_LINES | Transmission completed on the line |
| tx_done_ready | output | NUM_LINES | Completion consumed this cycle |
| tx_byte | input | 8*NUM_LINES | Transmitted character, line n at bits 8n+7:8n |
| rd_en | input | 1 | Read strobe, pops one word |
| rd_data | output | 16 | Popped word, or zero on an empty read |
| rx_done | output | 1 | Received data waiting |

## Verification
The assertions assume that every producer holds valid and its payload until ready, and that clear and reset are the only ways the queue empties besides reads. The checker keeps its own word count from the handshakes and read strobes at the ports. The bench drives each producer through a task that holds its payload until it sees ready, then releases it. Read strobes and clears are single-cycle pulses applied between rising edges, so every handshake the checker counts matches what the queue actually saw.

// File: rtl/tagged_rx_queue_pkg.sv
package tagged_rx_queue_pkg;

  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;
  localparam int TAG_W  = 2;

  typedef struct packed {
    logic              valid;
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [1:0]        pad;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] chr;
  } entry_t;

  function automatic entry_t pack_entry(input logic [TAG_W-1:0] line,
                                        input logic [CHAR_W-1:0] chr,
                                        input logic ferr,
                                        input logic perr);
    entry_t e;
    e.valid = 1'b1;
    e.ovr   = 1'b0;
    e.ferr  = ferr;
    e.perr  = perr;
    e.pad   = 2'b00;
    e.line  = line;
    e.chr   = chr;
    return e;
  endfunction

endpackage

// File: rtl/trq_req_former.sv
module trq_req_former
  import tagged_rx_queue_pkg::*;
#(
  parameter int NUM_LINES = 4,
  localparam int REQ_N = 2 * NUM_LINES
) (
  input  logic                          loop_en,
  input  logic [NUM_LINES-1:0]          rx_valid,
  input  logic [NUM_LINES*CHAR_W-1:0]   rx_byte,
  input  logic [NUM_LINES-1:0]          rx_ferr,
  input  logic [NUM_LINES-1:0]          rx_perr,
  input  logic [NUM_LINES-1:0]          tx_done_valid,
  input  logic [NUM_LINES*CHAR_W-1:0]   tx_byte,
  output logic [REQ_N-1:0]              req,
  output logic [REQ_N-1:0][WORD_W-1:0]  words
);

  // Requester 2*l is line l's receiver, 2*l+1 its loopback source;
  // the arbiter's low-index-first rule gives the required ranking.
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    localparam logic [TAG_W-1:0] TAG = TAG_W'(l);
    assign req[2*l]     = rx_valid[l];
    assign req[2*l+1]   = tx_done_valid[l] & loop_en;
    assign words[2*l]   = pack_entry(TAG, rx_byte[l*CHAR_W +: CHAR_W],
                                     rx_ferr[l], rx_perr[l]);
    assign words[2*l+1] = pack_entry(TAG, tx_byte[l*CHAR_W +: CHAR_W],
                                     1'b0, 1'b0);
  end

endmodule

// File: rtl/trq_arbiter.sv
module trq_arbiter
  import tagged_rx_queue_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][WORD_W-1:0] words,
  output logic [N-1:0]             grant,
  output logic                     any,
  output logic [WORD_W-1:0]        word
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    word  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        word     = words[i];
        found    = 1'b1;
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/trq_store.sv
module trq_store
  import tagged_rx_queue_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push_valid,
  input  logic [WORD_W-1:0] push_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rx_done
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;
  logic              acc, pop;

  assign acc = push_valid && (count != FULL_CNT) && !clr;
  assign pop = rd_en && (count != '0) && !clr;

  always_ff @(posedge clk) begin
    if (acc) mem[wptr] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rx_done <= 1'b0;
      rd_data <= '0;
    end else if (clr) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      rx_done <= 1'b0;
      rd_data <= '0;
    end else begin
      if (acc) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop) rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      if (rd_en) rd_data <= pop ? mem[rptr] : '0;
      case ({acc, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (acc)
        rx_done <= 1'b1;
      else if (rd_en && (count == '0 || count == CNT_W'(1)))
        rx_done <= 1'b0;
    end
  end

endmodule

// File: rtl/tagged_rx_queue.sv
module tagged_rx_queue
  import tagged_rx_queue_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         loop_en,
  input  logic [NUM_LINES-1:0]         rx_valid,
  output logic [NUM_LINES-1:0]         rx_ready,
  input  logic [NUM_LINES*CHAR_W-1:0]  rx_byte,
  input  logic [NUM_LINES-1:0]         rx_ferr,
  input  logic [NUM_LINES-1:0]         rx_perr,
  input  logic [NUM_LINES-1:0]         tx_done_valid,
  output logic [NUM_LINES-1:0]         tx_done_ready,
  input  logic [NUM_LINES*CHAR_W-1:0]  tx_byte,
  input  logic                         rd_en,
  output logic [WORD_W-1:0]            rd_data,
  output logic                         rx_done
);

  localparam int REQ_N = 2 * NUM_LINES;

  logic [REQ_N-1:0]             req, grant;
  logic [REQ_N-1:0][WORD_W-1:0] words;
  logic                         any;
  logic [WORD_W-1:0]            word;

  trq_req_former #(.NUM_LINES(NUM_LINES)) u_former (
    .loop_en       (loop_en),
    .rx_valid      (rx_valid),
    .rx_byte       (rx_byte),
    .rx_ferr       (rx_ferr),
    .rx_perr       (rx_perr),
    .tx_done_valid (tx_done_valid),
    .tx_byte       (tx_byte),
    .req           (req),
    .words         (words)
  );

  trq_arbiter #(.N(REQ_N)) u_arb (
    .req   (req),
    .words (words),
    .grant (grant),
    .any   (any),
    .word  (word)
  );

  trq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .push_valid (any),
    .push_word  (word),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rx_done    (rx_done)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_ready
    assign rx_ready[l]      = grant[2*l];
    assign tx_done_ready[l] = grant[2*l+1] | ~loop_en;
  end

endmodule

// File: rtl/tagged_rx_queue_checker.sv
module tagged_rx_queue_checker #(
  parameter int NUM_LINES = 4,
  parameter int DEPTH     = 64,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 clr,
  input logic                 loop_en,
  input logic [NUM_LINES-1:0] rx_valid,
  input logic [NUM_LINES-1:0] rx_ready,
  input logic [NUM_LINES-1:0] tx_done_valid,
  input logic [NUM_LINES-1:0] tx_done_ready,
  input logic                 rd_en,
  input logic [15:0]          rd_data,
  input logic                 rx_done
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [NUM_LINES-1:0] rx_fire, lb_fire;
  logic                 fire, stored, popped;
  logic [CNT_W-1:0]     occ;

  assign rx_fire = rx_valid & rx_ready;
  assign lb_fire = tx_done_valid & tx_done_ready & {NUM_LINES{loop_en}};
  assign fire    = |{rx_fire, lb_fire};
  assign stored  = fire && (occ != FULL_CNT) && !clr;
  assign popped  = rd_en && (occ != '0) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (clr)    occ <= '0;
    else if (stored && !popped) occ <= occ + 1'b1;
    else if (popped && !stored) occ <= occ - 1'b1;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rx_fire, lb_fire}) <= 1); // R2

  AST_LINE0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid[0] |-> rx_ready[0]); // R2

  AST_STORE_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stored |=> rx_done); // R4

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && occ == '0 && !fire) |=> (rd_data == 16'h0000 && !rx_done)); // R5

  AST_DONE_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done == (occ != '0)); // R6

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rx_done && rd_data == 16'h0000)); // R8

endmodule

bind tagged_rx_queue tagged_rx_queue_checker #(
  .NUM_LINES (NUM_LINES),
  .DEPTH     (DEPTH)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .clr           (clr),
  .loop_en       (loop_en),
  .rx_valid      (rx_valid),
  .rx_ready      (rx_ready),
  .tx_done_valid (tx_done_valid),
  .tx_done_ready (tx_done_ready),
  .rd_en         (rd_en),
  .rd_data       (rd_data),
  .rx_done       (rx_done)
);

// File: tb/tagged_rx_queue_test.sv
`timescale 1ns/1ps
module tagged_rx_queue_test;

  localparam int NL = 4;
  localparam int DP = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic          loop_en = 1'b0;
  logic [NL-1:0] rx_valid = '0;
  logic [NL-1:0] rx_ready;
  logic [NL*8-1:0] rx_byte = '0;
  logic [NL-1:0] rx_ferr = '0;
  logic [NL-1:0] rx_perr = '0;
  logic [NL-1:0] tx_done_valid = '0;
  logic [NL-1:0] tx_done_ready;
  logic [NL*8-1:0] tx_byte = '0;
  logic          rd_en = 1'b0;
  logic [15:0]   rd_data;
  logic          rx_done;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tagged_rx_queue #(.NUM_LINES(NL), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .loop_en(loop_en),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_byte(rx_byte),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr),
    .tx_done_valid(tx_done_valid), .tx_done_ready(tx_done_ready),
    .tx_byte(tx_byte), .rd_en(rd_en), .rd_data(rd_data), .rx_done(rx_done)
  );

  function automatic logic [15:0] exp_word(input int l, input logic [7:0] d,
                                            input logic f, input logic p);
    return {1'b1, 1'b0, f, p, 2'b00, 2'(l), d};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report_end();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic push_rx(input int l, input logic [7:0] d, input logic f, input logic p);
    @(negedge clk);
    rx_valid[l] = 1'b1;
    rx_byte[l*8 +: 8] = d;
    rx_ferr[l] = f;
    rx_perr[l] = p;
    #1;
    while (!rx_ready[l]) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_valid[l] = 1'b0;
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R8 reset rx_done", 16'(rx_done), 16'h0);
    check("R8 reset rd_data", rd_data, 16'h0);
    do_read(v);
    check("R5 empty read data", v, 16'h0);
    check("R5 empty read rx_done", 16'(rx_done), 16'h0);
  endtask

  task automatic t_single();
    logic [15:0] v;
    push_rx(2, 8'hA5, 1'b1, 1'b0);
    check("R4 store sets rx_done", 16'(rx_done), 16'h1);
    do_read(v);
    check("R1 layout framing word", v, 16'hA2A5);
    check("R6 last read clears rx_done", 16'(rx_done), 16'h0);
    push_rx(3, 8'h0F, 1'b0, 1'b1);
    do_read(v);
    check("R1 layout parity word", v, 16'h930F);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    logic [NL-1:0] gr, gt;
    loop_en = 1'b1;
    @(negedge clk);
    rx_valid = 4'b1011;
    rx_byte  = {8'h33, 8'h00, 8'h22, 8'h11};
    rx_ferr  = '0;
    rx_perr  = '0;
    tx_done_valid = 4'b0001;
    tx_byte  = {24'h0, 8'h44};
    #1;
    check("R2 first grant line0 rx", {8'h0, rx_ready, tx_done_ready}, 16'h0010);
    repeat (4) begin
      #1;
      gr = rx_ready;
      gt = tx_done_ready;
      @(negedge clk);
      rx_valid      = rx_valid & ~gr;
      tx_done_valid = tx_done_valid & ~gt;
    end
    check("R2 all producers consumed", {8'h0, rx_valid, tx_done_valid}, 16'h0);
    do_read(v); check("R2 order 1st", v, 16'h8011);
    do_read(v); check("R7 loopback 2nd", v, 16'h8044);
    do_read(v); check("R2 order 3rd", v, 16'h8122);
    do_read(v); check("R2 order 4th", v, 16'h8333);
    check("R6 drained rx_done", 16'(rx_done), 16'h0);
  endtask

  task automatic t_loop_off();
    logic [15:0] v;
    loop_en = 1'b0;
    @(negedge clk);
    tx_done_valid[2] = 1'b1;
    tx_byte[16 +: 8] = 8'h5C;
    #1;
    check("R7 loop off ready", 16'(tx_done_ready[2]), 16'h1);
    @(negedge clk);
    tx_done_valid[2] = 1'b0;
    check("R7 loop off no rx_done", 16'(rx_done), 16'h0);
    do_read(v);
    check("R7 loop off nothing stored", v, 16'h0);
  endtask

  task automatic t_full();
    logic [15:0] v;
    for (int i = 0; i < DP; i++) push_rx(0, 8'(i), 1'b0, 1'(i));
    push_rx(3, 8'hFF, 1'b1, 1'b1);
    check("R3 dropped push still done", 16'(rx_done), 16'h1);
    for (int i = 0; i < DP; i++) begin
      do_read(v);
      if (i == 0 || i == DP - 1 || v !== exp_word(0, 8'(i), 1'b0, 1'(i)))
        check("R10 full order", v, exp_word(0, 8'(i), 1'b0, 1'(i)));
    end
    do_read(v);
    check("R3 overflow word discarded", v, 16'h0);
    check("R5 after drain rx_done", 16'(rx_done), 16'h0);
  endtask

  task automatic t_push_pop();
    logic [15:0] v;
    push_rx(1, 8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    rx_valid[2] = 1'b1;
    rx_byte[16 +: 8] = 8'h6B;
    rx_ferr[2] = 1'b0;
    rx_perr[2] = 1'b0;
    rd_en = 1'b1;
    @(negedge clk);
    rx_valid[2] = 1'b0;
    rd_en = 1'b0;
    check("R9 same-cycle read data", rd_data, 16'h815A);
    check("R9 rx_done kept", 16'(rx_done), 16'h1);
    do_read(v);
    check("R9 pushed word kept", v, 16'h826B);
    do_read(v);
    check("R9 count unchanged then empty", v, 16'h0);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    push_rx(0, 8'h01, 1'b0, 1'b0);
    push_rx(1, 8'h02, 1'b0, 1'b0);
    push_rx(2, 8'h03, 1'b0, 1'b0);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check("R8 clear rx_done", 16'(rx_done), 16'h0);
    do_read(v);
    check("R8 clear empties", v, 16'h0);
    push_rx(3, 8'h77, 1'b0, 1'b0);
    do_read(v);
    check("R8 after clear fresh word", v, 16'h8377);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report_end();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_priority();
    t_loop_off();
    t_full();
    t_push_pop();
    t_clear();
    report_end();
  end

endmodule